// File: doc/BRIEF.md
# Multichannel audio frame assembler

The block builds one multichannel audio frame per sampling period and sends it as a single serial bit stream. Up to `NUM_CH` mono channels (56 by default) are held in a per-channel store. A small write port loads that store with the channel index, the 24-bit sample, an active flag and the validity, user and channel-status bits. Each frame is a sequence of 32-bit channel slots, one for every channel in ascending index order. A slot uses the two-channel subframe layout:

- slot bits 0–3 carry a 4-bit header of channel markers;
- slot bits 4–27 carry the audio word, least significant bit at bit 4;
- slot bits 28–31 carry validity, user, channel status and an even parity bit.

A frame starts on the sample-period strobe `fs_i`. The first bit of channel 0 is flagged on `frame_o`, and one slot bit follows per clock until all slots have gone out. A strobe that arrives while a frame is still being sent is dropped and reported on `overrun_o`. The exception is a strobe in the cycle of the frame's final bit: it chains the next frame without a gap. Frames are counted in blocks of `BLOCK_FRAMES` (192 by default), and every slot of a block's first frame carries a sync marker. Line coding and the physical layer are handled downstream.

Top module: `mch_frame_asm`

## Requirements
- R1: After reset `ser_o`, `frame_o` and `overrun_o` are low, and every channel is stored inactive with zero sample and zero V/U/C bits.
- R2: When `fs_i` is high at a clock edge while idle, the first bit of the frame is on `ser_o` after that edge. `frame_o` is high for exactly that one cycle. `NUM_CH`×32 bits then follow on consecutive cycles, after which `ser_o` and `frame_o` stay low until the next accepted strobe.
- R3: Each slot is sent in this order: header bit 3, header bit 2, header bit 1, header bit 0, then the audio word most significant bit first, then V, U, C and P.
- R4: Header bit 0 is 1 in the slot of channel 0 and 0 in every other slot.
- R5: Header bit 1 is the channel's active flag. An inactive channel is still sent in its slot, with an all-zero audio word and its stored V/U/C bits.
- R6: Header bit 2 is the A/B flag. It is 1 for odd channel indices and 0 for even ones.
- R7: Header bit 3 is 1 in every slot of the first frame of each block of `BLOCK_FRAMES` accepted frames, and 0 otherwise. The first frame after reset opens a block.
- R8: The parity bit P makes slot bits 4–31 contain an even number of ones.
- R9: `fs_i` high while a frame is being sent, except in the cycle of the frame's final bit, raises `overrun_o` for one cycle after that edge. The strobe is otherwise ignored: the running frame continues unchanged and no new frame follows.
- R10: `fs_i` high in the cycle of a frame's final bit starts the next frame on the following cycle, with no idle cycle and no overrun.
- R11: A write whose channel index is `NUM_CH` or larger changes no channel's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fs_i | input | 1 | Sample-period strobe |
| wr_en_i | input | 1 | Channel write enable |
| wr_ch_i | input | $clog2(NUM_CH) | Channel index of the write |
| wr_sample_i | input | 24 | Audio sample, two's complement |
| wr_active_i | input | 1 | Channel active flag |
| wr_valid_i | input | 1 | Validity bit |
| wr_user_i | input | 1 | User bit |
| wr_cstat_i | input | 1 | Channel-status bit |
| ser_o | output | 1 | Serial frame bit stream |
| frame_o | output | 1 | High with the first bit of channel 0 |
| overrun_o | output | 1 | One-cycle pulse for a dropped strobe |

## Verification
Two events can fall in the same cycle: the end of a frame's last slot and a new sample-period strobe. The bench raises `fs_i` exactly in the final-bit cycle and expects a gapless next frame, with `frame_o` one cycle later and no overrun. It also raises `fs_i` one cycle earlier and expects an overrun pulse, followed by a clean idle line after the last bit. In every case the slots of the running frame and of the chained frame are compared field by field against the bench's own slot model.

// File: rtl/mch_pkg.sv
package mch_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 32;

  typedef struct packed {
    logic                active;
    logic [SAMPLE_W-1:0] sample;
    logic                valid;
    logic                user;
    logic                cstat;
  } chan_t;

  // tx word: bit SLOT_W-1 leaves first
  function automatic logic [SLOT_W-1:0] pack_slot(chan_t ch, logic first, logic ab, logic sync);
    logic [SAMPLE_W-1:0] aud;
    logic                par;
    aud = ch.active ? ch.sample : '0;
    par = ^{aud, ch.valid, ch.user, ch.cstat};
    return {sync, ab, ch.active, first, aud, ch.valid, ch.user, ch.cstat, par};
  endfunction
endpackage

// File: rtl/mch_chan_store.sv
module mch_chan_store
  import mch_pkg::*;
#(
  parameter int NUM_CH = 56,
  localparam int CH_IW = $clog2(NUM_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CH_IW-1:0] wr_ch_i,
  input  chan_t            wr_data_i,
  input  logic [CH_IW-1:0] rd_ch_i,
  output chan_t            rd_data_o
);
  chan_t mem_q [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
    end else if (wr_en_i && (32'(wr_ch_i) < NUM_CH)) begin
      mem_q[wr_ch_i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (32'(rd_ch_i) < NUM_CH) rd_data_o = mem_q[rd_ch_i];
  end
endmodule

// File: rtl/mch_slot_seq.sv
module mch_slot_seq
  import mch_pkg::*;
#(
  parameter int NUM_CH       = 56,
  parameter int BLOCK_FRAMES = 192,
  localparam int CH_IW  = $clog2(NUM_CH),
  localparam int BIT_W  = $clog2(SLOT_W),
  localparam int BLK_W  = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fs_i,
  output logic             load_o,
  output logic [CH_IW-1:0] load_ch_o,
  output logic             load_sync_o,
  output logic             frame_o,
  output logic             overrun_o
);
  logic             busy_q, sync_q, overrun_q;
  logic [CH_IW-1:0] ch_q;
  logic [BIT_W-1:0] bit_q;
  logic [BLK_W-1:0] blk_q;
  logic             last_bit, last, start;

  assign last_bit = (bit_q == BIT_W'(SLOT_W-1));
  assign last     = busy_q && last_bit && (ch_q == CH_IW'(NUM_CH-1));
  assign start    = fs_i && (!busy_q || last);

  assign load_o      = start || (busy_q && last_bit && !last);
  assign load_ch_o   = start ? '0 : ch_q + 1'b1;
  assign load_sync_o = start ? (blk_q == '0) : sync_q;
  assign frame_o     = busy_q && (ch_q == '0) && (bit_q == '0);
  assign overrun_o   = overrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      sync_q    <= 1'b0;
      overrun_q <= 1'b0;
      ch_q      <= '0;
      bit_q     <= '0;
      blk_q     <= '0;
    end else begin
      overrun_q <= fs_i && busy_q && !last;
      if (start) begin
        busy_q <= 1'b1;
        ch_q   <= '0;
        bit_q  <= '0;
        sync_q <= (blk_q == '0);
        blk_q  <= (blk_q == BLK_W'(BLOCK_FRAMES-1)) ? '0 : blk_q + 1'b1;
      end else if (busy_q) begin
        bit_q <= bit_q + 1'b1;
        if (last_bit) begin
          if (last) busy_q <= 1'b0;
          else      ch_q   <= ch_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mch_shifter.sv
module mch_shifter
  import mch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] word_i,
  output logic              ser_o
);
  logic [SLOT_W-1:0] sh_q;

  // 32 shifts per slot empty the register, so the line idles low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= word_i;
    else             sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
  end

  assign ser_o = sh_q[SLOT_W-1];
endmodule

// File: rtl/mch_frame_asm.sv
module mch_frame_asm
  import mch_pkg::*;
#(
  parameter int NUM_CH       = 56,
  parameter int BLOCK_FRAMES = 192,
  localparam int CH_IW = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fs_i,
  input  logic                wr_en_i,
  input  logic [CH_IW-1:0]    wr_ch_i,
  input  logic [SAMPLE_W-1:0] wr_sample_i,
  input  logic                wr_active_i,
  input  logic                wr_valid_i,
  input  logic                wr_user_i,
  input  logic                wr_cstat_i,
  output logic                ser_o,
  output logic                frame_o,
  output logic                overrun_o
);
  chan_t             wr_data, rd_data;
  logic              load, load_sync;
  logic [CH_IW-1:0]  load_ch;
  logic [SLOT_W-1:0] word;

  assign wr_data = '{active: wr_active_i, sample: wr_sample_i,
                     valid: wr_valid_i, user: wr_user_i, cstat: wr_cstat_i};

  mch_chan_store #(.NUM_CH(NUM_CH)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_ch_i,
    .wr_data_i(wr_data), .rd_ch_i(load_ch), .rd_data_o(rd_data)
  );

  mch_slot_seq #(.NUM_CH(NUM_CH), .BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk_i, .rst_ni, .fs_i,
    .load_o(load), .load_ch_o(load_ch), .load_sync_o(load_sync),
    .frame_o, .overrun_o
  );

  assign word = pack_slot(rd_data, load_ch == '0, load_ch[0], load_sync);

  mch_shifter u_shift (
    .clk_i, .rst_ni, .load_i(load), .word_i(word), .ser_o
  );
endmodule

// File: rtl/mch_frame_asm_chk.sv
module mch_frame_asm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fs_i,
  input logic ser_o,
  input logic frame_o,
  input logic overrun_o
);
  assert_frame_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  assert_frame_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> $past(fs_i));

  // header bit 0 of channel 0 is the fourth bit after frame start
  assert_first_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_o, 3) |-> ser_o);

  assert_overrun_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(fs_i));

  assert_overrun_no_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> !frame_o);
endmodule

bind mch_frame_asm mch_frame_asm_chk u_chk (.*);

// File: tb/mch_frame_asm_test.sv
`timescale 1ns/1ps
module mch_frame_asm_test;
  localparam int NCH = 56;
  localparam int BLK = 4;
  localparam int TOT = NCH * 32;
  localparam int IW  = $clog2(NCH);

  logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0;
  logic wr_en = 1'b0, wr_act = 1'b0, wr_v = 1'b0, wr_u = 1'b0, wr_c = 1'b0;
  logic [IW-1:0] wr_ch = '0;
  logic [23:0]   wr_smp = '0;
  logic ser, frm, ovr;

  always #2.5 clk = ~clk;

  mch_frame_asm #(.NUM_CH(NCH), .BLOCK_FRAMES(BLK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fs_i(fs), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_sample_i(wr_smp), .wr_active_i(wr_act), .wr_valid_i(wr_v),
    .wr_user_i(wr_u), .wr_cstat_i(wr_c),
    .ser_o(ser), .frame_o(frm), .overrun_o(ovr)
  );

  int n_cmp = 0, n_bad = 0, frame_idx = 0;
  bit done = 0;
  logic [23:0] m_smp [NCH];
  bit m_act [NCH], m_v [NCH], m_u [NCH], m_c [NCH];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] exp_slot(input int c, input bit sync);
    logic [23:0] aud;
    bit p;
    aud = m_act[c] ? m_smp[c] : 24'd0;
    p = ^{aud, m_v[c], m_u[c], m_c[c]};
    return {sync, 1'(c % 2), m_act[c], (c == 0), aud, m_v[c], m_u[c], m_c[c], p};
  endfunction

  task automatic write_ch(input int c, input logic [23:0] s, input bit a, input bit v, input bit u, input bit cs);
    wr_en = 1; wr_ch = IW'(c); wr_smp = s; wr_act = a; wr_v = v; wr_u = u; wr_c = cs;
    @(negedge clk);
    wr_en = 0;
    if (c < NCH) begin
      m_smp[c] = s; m_act[c] = a; m_v[c] = v; m_u[c] = u; m_c[c] = cs;
    end
  endtask

  task automatic write_random();
    for (int c = 0; c < NCH; c++)
      write_ch(c, 24'($urandom), bit'($urandom % 4 != 0), bit'($urandom), bit'($urandom), bit'($urandom));
  endtask

  // call at the negedge where the first bit is visible
  task automatic receive_frame(input int strobe_at);
    logic [31:0] got, e;
    bit sync, eo;
    sync = (frame_idx % BLK) == 0;
    frame_idx++;
    got = '0;
    for (int i = 0; i < TOT; i++) begin
      chk(frm === (i == 0), "R2 frame_o", 32'(frm), 32'(i == 0));
      eo = (strobe_at >= 0) && (i == strobe_at + 1);
      chk(ovr === eo, eo ? "R9 overrun_o" : "R10 overrun_o", 32'(ovr), 32'(eo));
      got = {got[30:0], ser};
      if (i % 32 == 31) begin
        e = exp_slot(i / 32, sync);
        chk(got[28] === e[28], "R4 first flag", got, e);
        chk(got[29] === e[29], "R5 active flag", got, e);
        chk(got[30] === e[30], "R6 ab flag", got, e);
        chk(got[31] === e[31], "R7 sync flag", got, e);
        chk(got[27:1] === e[27:1], "R3 audio/vuc order", got, e);
        chk(got[0] === e[0], "R8 parity", got, e);
      end
      fs = (i == strobe_at);
      @(negedge clk);
    end
    fs = 0;
  endtask

  task automatic start_frame();
    fs = 1;
    @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    chk(ser === 1'b0 && frm === 1'b0 && ovr === 1'b0, tag, {ser, frm, ovr}, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin
      m_smp[c] = '0; m_act[c] = 0; m_v[c] = 0; m_u[c] = 0; m_c[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 4; k++) begin
      check_idle("R1 reset outputs");
      @(negedge clk);
    end

    // R1 R7: frame 0 from reset contents, opens a block
    start_frame(); receive_frame(-1);
    check_idle("R2 idle after frame");
    @(negedge clk);

    // R11: out-of-range write must not disturb any slot
    write_random();
    write_ch(NCH + 4, 24'hA5A5A5, 1, 1, 1, 1);
    write_ch(63, 24'hFFFFFF, 1, 1, 0, 1);
    start_frame(); receive_frame(700);   // R9 mid-frame strobe, R11 slots intact
    check_idle("R9 no restart after overrun");
    @(negedge clk);

    write_random();
    write_ch(0, 24'hFFFFFF, 1, 1, 1, 1);
    write_ch(1, 24'h800000, 0, 1, 0, 1);
    write_ch(NCH - 1, 24'h000001, 1, 0, 0, 0);
    start_frame(); receive_frame(TOT - 2);  // R9 strobe one cycle before final bit
    check_idle("R9 idle after late overrun");
    @(negedge clk);

    // R10: strobe on the final bit chains frames back to back
    start_frame(); receive_frame(TOT - 1);
    chk(ovr === 1'b0, "R10 no overrun on chain", 32'(ovr), 0);
    receive_frame(TOT - 1);
    receive_frame(-1);
    check_idle("R2 idle after chain");
    @(negedge clk);

    for (int f = 0; f < 3; f++) begin
      write_random();
      start_frame(); receive_frame(-1);
      @(negedge clk);
    end
    summary();
  end
endmodule